// File: doc/BRIEF.md
# Digital Phase-Tracking Loop with Quadrature Interpolator Control

This block closes the digital part of the phase-recovery loop in a dual-loop clock and data recovery receiver. Each clock it takes one signed vote from a bang-bang phase detector. The vote says to move the sampling phase later, to move it earlier, or to hold. The vote feeds two filter paths. The proportional path acts on the current vote only. The integral path keeps a saturating running sum that tracks frequency offset. The sum of the two paths, limited to a programmable largest step, is added to a wrapping phase accumulator that carries fractional bits.

The top seven bits of the accumulator form the phase code. It is split into a 2-bit quadrant and a 5-bit fine position. The quadrant sets the signs of the in-phase (I) and quadrature (Q) clocks. The fine position sets two linear mixing weights that always sum to 31. Because the weights swap roles in odd quadrants, the resulting phase rises steadily through a full turn and wraps in either direction.

Both gains and the step limit are run-time inputs. A freeze input holds the loop while a frequency loop is in charge. The integral register is visible at the ports for monitoring.

Top module: `phtrk_loop`

## Requirements
- R1: While rst_n is low, phase_code, quad, i_neg, q_neg, wt_a and integ_mon are all 0, and wt_b is 31.
- R2: pd_vote 2'b01 is a late vote (+1) and 2'b11 is an early vote (-1). The codes 2'b00 and 2'b10 are no vote: they leave integ_mon unchanged and give a zero proportional term.
- R3: One code step is 256 accumulator units. In the clock where a vote is sampled, the proportional term is ±4096 arithmetically right-shifted by kp_shift. It counts toward that same clock's accumulator update.
- R4: In each clock with a vote and no freeze, integ_mon gains ±4096 arithmetically right-shifted by ki_shift. The shift rounds toward minus infinity, so -4096>>>15 is -1. Each accumulator update adds the proportional term plus the integ_mon value held before that clock edge.
- R5: integ_mon saturates at +32767 and -32768 and never wraps.
- R6: The accumulator is 15 bits (7 code bits over 8 fraction bits) and wraps modulo 2^15. phase_code therefore wraps modulo 128: 127 steps forward to 0, and 0 steps backward to 127.
- R7: The magnitude of each accumulator update is limited to max_step×256, so phase_code moves by at most max_step codes (modulo 128) per clock. A max_step of 0 stops the phase.
- R8: While freeze is high at a clock edge, both the accumulator and integ_mon keep their values.
- R9: quad is phase_code[6:5]. i_neg is high in quadrants 1 and 2, and q_neg is high in quadrants 2 and 3.
- R10: With fine = phase_code[4:0]: in even quadrants wt_a = fine and wt_b = 31 - fine; in odd quadrants wt_a = 31 - fine and wt_b = fine. wt_a weights the Q clock and wt_b weights the I clock, and wt_a + wt_b is always 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loop clock; one vote is sampled per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_vote | input | 2 | Phase detector vote: 01 late, 11 early, 00/10 none |
| freeze | input | 1 | Holds the accumulator and the integral register |
| kp_shift | input | 4 | Proportional gain as an arithmetic right shift |
| ki_shift | input | 4 | Integral gain as an arithmetic right shift |
| max_step | input | 4 | Largest phase_code change per clock, in codes |
| phase_code | output | 7 | Current interpolator phase code |
| quad | output | 2 | Quadrant of the phase code |
| i_neg | output | 1 | Invert the I clock into the mixer |
| q_neg | output | 1 | Invert the Q clock into the mixer |
| wt_a | output | 5 | Mixing weight applied to the Q clock |
| wt_b | output | 5 | Mixing weight applied to the I clock |
| integ_mon | output | 16 | Signed integral register, for monitoring |

## Verification
A vote, gain, step limit or freeze sampled at a rising edge shows up in phase_code and integ_mon right after that same edge. The quadrant, polarity and weight outputs are combinational decodes of phase_code, so they are due in the same cycle. The integral term reaches the phase one edge later, because each update uses the integral value held before the edge. The bench sets its inputs 2 ns after a rising edge and compares all outputs 2 ns after the next rising edge, so every comparison falls exactly one register stage after its stimulus. The expected values in the table and in the directed tests come from hand arithmetic on the 256-unit code scale.

// File: rtl/phtrk_pkg.sv
package phtrk_pkg;

   // Quadrant field is fixed by the quadrature structure of the mixer.
   localparam int QUAD_W = 2;

   // Map the two-bit detector code to a signed vote (+1 late, -1 early).
   function automatic logic signed [1:0] vote_decode(input logic [1:0] code);
      logic signed [1:0] v;
      case (code)
         2'b01:   v = 2'sb01;
         2'b11:   v = 2'sb11;
         default: v = 2'sb00;
      endcase
      return v;
   endfunction

endpackage

// File: rtl/phtrk_filter.sv
module phtrk_filter #(
   parameter int IW      = 16,
   parameter int FRAC_W  = 8,
   parameter int GAIN_SH = 4,
   parameter int SHIFT_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 freeze,
   input  logic signed [1:0]    vote,
   input  logic [SHIFT_W-1:0]   kp_shift,
   input  logic [SHIFT_W-1:0]   ki_shift,
   output logic signed [IW-1:0] prop,
   output logic signed [IW-1:0] integ
);

   localparam int BASE = 1 << (FRAC_W + GAIN_SH);
   localparam logic signed [IW-1:0] I_MAX = {1'b0, {(IW-1){1'b1}}};
   localparam logic signed [IW-1:0] I_MIN = {1'b1, {(IW-1){1'b0}}};

   if (FRAC_W + GAIN_SH > IW - 2) begin : g_bad_base
      $error("phtrk_filter: vote base does not fit the integral width");
   end

   logic signed [IW-1:0] base_term;
   logic signed [IW-1:0] inc;
   logic signed [IW:0]   wide_sum;
   logic signed [IW-1:0] integ_nx;

   always_comb begin
      case (vote)
         2'sb01:  base_term = IW'(BASE);
         2'sb11:  base_term = -IW'(BASE);
         default: base_term = '0;
      endcase
   end

   assign prop = base_term >>> kp_shift;
   assign inc  = base_term >>> ki_shift;

   // One guard bit detects overflow; clamp to the signed limits.
   assign wide_sum = {integ[IW-1], integ} + {inc[IW-1], inc};

   always_comb begin
      if (wide_sum[IW] != wide_sum[IW-1])
         integ_nx = wide_sum[IW] ? I_MIN : I_MAX;
      else
         integ_nx = wide_sum[IW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         integ <= '0;
      else if (!freeze)
         integ <= integ_nx;
   end

endmodule

// File: rtl/phtrk_accum.sv
module phtrk_accum #(
   parameter int PH_W   = 7,
   parameter int FRAC_W = 8,
   parameter int IW     = 16,
   parameter int STEP_W = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 freeze,
   input  logic signed [IW-1:0] prop,
   input  logic signed [IW-1:0] integ,
   input  logic [STEP_W-1:0]    max_step,
   output logic [PH_W-1:0]      phase_code
);

   localparam int AW    = PH_W + FRAC_W;
   localparam int RAW_W = IW + 1;
   localparam int LIM_W = STEP_W + FRAC_W + 1;
   localparam int SW    = ((RAW_W > LIM_W) ? RAW_W : LIM_W) + 1;

   if (PH_W < 3) begin : g_bad_phase
      $error("phtrk_accum: phase code too narrow for a quadrant field");
   end

   logic [AW-1:0]        acc;
   logic signed [SW-1:0] raw;
   logic signed [SW-1:0] lim;
   logic signed [SW-1:0] step;

   assign raw = SW'(prop) + SW'(integ);
   assign lim = $signed(SW'(max_step)) <<< FRAC_W;

   // A whole-code limit keeps the integer field move bounded by max_step.
   always_comb begin
      if (raw > lim)
         step = lim;
      else if (raw < -lim)
         step = -lim;
      else
         step = raw;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc <= '0;
      else if (!freeze)
         acc <= acc + AW'(step);
   end

   assign phase_code = acc[AW-1 -: PH_W];

endmodule

// File: rtl/phtrk_pimap.sv
module phtrk_pimap
   import phtrk_pkg::*;
#(
   parameter int FINE_W = 5,
   parameter int PH_W   = FINE_W + QUAD_W
) (
   input  logic [PH_W-1:0]   phase_code,
   output logic [QUAD_W-1:0] quad,
   output logic              i_neg,
   output logic              q_neg,
   output logic [FINE_W-1:0] wt_a,
   output logic [FINE_W-1:0] wt_b
);

   localparam logic [FINE_W-1:0] FULL = {FINE_W{1'b1}};

   if (PH_W != FINE_W + QUAD_W) begin : g_bad_split
      $error("phtrk_pimap: code width must be fine plus quadrant bits");
   end

   logic [FINE_W-1:0] fine;

   assign fine  = phase_code[FINE_W-1:0];
   assign quad  = phase_code[PH_W-1 -: QUAD_W];

   // Sign pattern walks I+Q+, I-Q+, I-Q-, I+Q- around the circle.
   assign i_neg = quad[1] ^ quad[0];
   assign q_neg = quad[1];

   // Odd quadrants swap the weights so the phase stays monotonic.
   assign wt_a  = quad[0] ? (FULL - fine) : fine;
   assign wt_b  = quad[0] ? fine : (FULL - fine);

endmodule

// File: rtl/phtrk_loop.sv
module phtrk_loop
   import phtrk_pkg::*;
#(
   parameter int FINE_W  = 5,
   parameter int FRAC_W  = 8,
   parameter int GAIN_SH = 4,
   parameter int IW      = 16,
   parameter int SHIFT_W = 4,
   parameter int STEP_W  = 4,
   localparam int PH_W   = FINE_W + QUAD_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [1:0]           pd_vote,
   input  logic                 freeze,
   input  logic [SHIFT_W-1:0]   kp_shift,
   input  logic [SHIFT_W-1:0]   ki_shift,
   input  logic [STEP_W-1:0]    max_step,
   output logic [PH_W-1:0]      phase_code,
   output logic [QUAD_W-1:0]    quad,
   output logic                 i_neg,
   output logic                 q_neg,
   output logic [FINE_W-1:0]    wt_a,
   output logic [FINE_W-1:0]    wt_b,
   output logic signed [IW-1:0] integ_mon
);

   logic signed [1:0]    vote_s;
   logic signed [IW-1:0] prop_term;
   logic signed [IW-1:0] integ_q;

   assign vote_s = vote_decode(pd_vote);

   phtrk_filter #(
      .IW(IW), .FRAC_W(FRAC_W), .GAIN_SH(GAIN_SH), .SHIFT_W(SHIFT_W)
   ) u_filter (
      .clk      (clk),
      .rst_n    (rst_n),
      .freeze   (freeze),
      .vote     (vote_s),
      .kp_shift (kp_shift),
      .ki_shift (ki_shift),
      .prop     (prop_term),
      .integ    (integ_q)
   );

   phtrk_accum #(
      .PH_W(PH_W), .FRAC_W(FRAC_W), .IW(IW), .STEP_W(STEP_W)
   ) u_accum (
      .clk        (clk),
      .rst_n      (rst_n),
      .freeze     (freeze),
      .prop       (prop_term),
      .integ      (integ_q),
      .max_step   (max_step),
      .phase_code (phase_code)
   );

   phtrk_pimap #(
      .FINE_W(FINE_W), .PH_W(PH_W)
   ) u_pimap (
      .phase_code (phase_code),
      .quad       (quad),
      .i_neg      (i_neg),
      .q_neg      (q_neg),
      .wt_a       (wt_a),
      .wt_b       (wt_b)
   );

   assign integ_mon = integ_q;

endmodule

// File: rtl/phtrk_loop_chk.sv
module phtrk_loop_chk #(
   parameter int FINE_W  = 5,
   parameter int IW      = 16,
   parameter int SHIFT_W = 4,
   parameter int STEP_W  = 4,
   parameter int PH_W    = FINE_W + 2
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [1:0]           pd_vote,
   input logic                 freeze,
   input logic [SHIFT_W-1:0]   kp_shift,
   input logic [SHIFT_W-1:0]   ki_shift,
   input logic [STEP_W-1:0]    max_step,
   input logic [PH_W-1:0]      phase_code,
   input logic [1:0]           quad,
   input logic                 i_neg,
   input logic                 q_neg,
   input logic [FINE_W-1:0]    wt_a,
   input logic [FINE_W-1:0]    wt_b,
   input logic signed [IW-1:0] integ_mon
);

   localparam int FULL = (1 << FINE_W) - 1;

   logic [PH_W-1:0] prev_code;
   logic [PH_W-1:0] prev_lim;
   logic [PH_W-1:0] d_fwd;
   logic [PH_W-1:0] d_bwd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_code <= '0;
         prev_lim  <= '0;
      end else begin
         prev_code <= phase_code;
         prev_lim  <= PH_W'(max_step);
      end
   end

   assign d_fwd = phase_code - prev_code;
   assign d_bwd = prev_code - phase_code;

   // R7: the code moves by at most the limit in force at the last edge.
   a_r7_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (d_fwd <= prev_lim) || (d_bwd <= prev_lim));

   // R8: freeze holds both the phase and the integral register.
   a_r8_freeze_hold: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> ($stable(phase_code) && $stable(integ_mon)));

   // R2: a no-vote code leaves the integral register alone.
   a_r2_idle_integ: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_vote == 2'b00 || pd_vote == 2'b10) |=> $stable(integ_mon));

   // R10: the two weights always add to full scale.
   a_r10_weight_sum: assert property (@(posedge clk) disable iff (!rst_n)
      ((32'(wt_a) + 32'(wt_b)) == FULL));

   // R9: the quadrant output follows the code's top field.
   a_r9_quad_field: assert property (@(posedge clk) disable iff (!rst_n)
      quad == phase_code[PH_W-1 -: 2]);

endmodule

bind phtrk_loop phtrk_loop_chk #(
   .FINE_W(FINE_W), .IW(IW), .SHIFT_W(SHIFT_W), .STEP_W(STEP_W), .PH_W(PH_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pd_vote    (pd_vote),
   .freeze     (freeze),
   .kp_shift   (kp_shift),
   .ki_shift   (ki_shift),
   .max_step   (max_step),
   .phase_code (phase_code),
   .quad       (quad),
   .i_neg      (i_neg),
   .q_neg      (q_neg),
   .wt_a       (wt_a),
   .wt_b       (wt_b),
   .integ_mon  (integ_mon)
);

// File: tb/phtrk_loop_test.sv
module phtrk_loop_test;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic [1:0]         pd_vote = 2'b00;
   logic               freeze = 1'b0;
   logic [3:0]         kp_shift = 4'd0;
   logic [3:0]         ki_shift = 4'd0;
   logic [3:0]         max_step = 4'd0;
   logic [6:0]         phase_code;
   logic [1:0]         quad;
   logic               i_neg;
   logic               q_neg;
   logic [4:0]         wt_a;
   logic [4:0]         wt_b;
   logic signed [15:0] integ_mon;

   int  n_chk  = 0;
   int  n_fail = 0;
   bit  done   = 1'b0;

   phtrk_loop uut (
      .clk(clk), .rst_n(rst_n), .pd_vote(pd_vote), .freeze(freeze),
      .kp_shift(kp_shift), .ki_shift(ki_shift), .max_step(max_step),
      .phase_code(phase_code), .quad(quad), .i_neg(i_neg), .q_neg(q_neg),
      .wt_a(wt_a), .wt_b(wt_b), .integ_mon(integ_mon)
   );

   always #5 clk = ~clk;

   // Stimulus table: one row per clock, starting from reset.
   localparam int NROW = 8;
   localparam logic [1:0] T_VOTE [0:NROW-1] =
      '{2'b01, 2'b01, 2'b11, 2'b00, 2'b10, 2'b01, 2'b01, 2'b11};
   localparam logic [3:0] T_KP   [0:NROW-1] = '{4, 4, 4, 4, 4, 4, 0, 0};
   localparam logic [3:0] T_MX   [0:NROW-1] = '{15, 15, 15, 15, 15, 15, 3, 2};
   localparam logic       T_FRZ  [0:NROW-1] = '{0, 0, 0, 0, 0, 1, 0, 0};
   localparam int         T_CODE [0:NROW-1] = '{1, 2, 1, 1, 1, 1, 4, 2};
   localparam int         T_INT  [0:NROW-1] = '{16, 32, 16, 16, 16, 16, 32, 16};
   localparam string      T_REQ  [0:NROW-1] =
      '{"R3", "R4", "R3", "R4", "R2", "R8", "R7", "R7"};

   task automatic check(input string req, input string what,
                        input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic int exp_wa(input int code);
      int fine = code % 32;
      return ((code / 32) % 2 == 1) ? 31 - fine : fine;
   endfunction

   task automatic check_map(input string req, input int code);
      int q = code / 32;
      check(req, "quad", int'(quad), q);
      check("R10", "wt_a", int'(wt_a), exp_wa(code));
      check("R10", "wt_b", int'(wt_b), 31 - exp_wa(code));
      check("R9", "i_neg", int'(i_neg), (q == 1 || q == 2) ? 1 : 0);
      check("R9", "q_neg", int'(q_neg), (q >= 2) ? 1 : 0);
   endtask

   task automatic tick();
      @(posedge clk);
      #2;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      pd_vote = 2'b00;
      freeze = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
   end

   initial begin
      // R1: reset state
      tick();
      tick();
      check("R1", "phase_code", int'(phase_code), 0);
      check("R1", "integ_mon", int'(integ_mon), 0);
      check("R1", "wt_a", int'(wt_a), 0);
      check("R1", "wt_b", int'(wt_b), 31);
      check("R1", "quad", int'(quad), 0);
      check("R1", "i_neg/q_neg", int'({i_neg, q_neg}), 0);
      rst_n = 1'b1;

      // Table walk: kp 4 -> 256, ki 8 -> 16 units per vote
      ki_shift = 4'd8;
      for (int r = 0; r < NROW; r++) begin
         pd_vote  = T_VOTE[r];
         kp_shift = T_KP[r];
         max_step = T_MX[r];
         freeze   = T_FRZ[r];
         tick();
         check(T_REQ[r], "phase_code", int'(phase_code), T_CODE[r]);
         check(T_REQ[r], "integ_mon", int'(integ_mon), T_INT[r]);
         check_map("R9", T_CODE[r]);
      end

      // R6: backward wrap, R4: negative rounding of the integral step
      do_reset();
      kp_shift = 4'd4; ki_shift = 4'd15; max_step = 4'd15;
      pd_vote = 2'b11;
      tick();
      check("R6", "phase_code back", int'(phase_code), 127);
      check("R4", "integ_mon -1", int'(integ_mon), -1);
      check_map("R9", 127);
      pd_vote = 2'b01;
      tick();
      check("R4", "code after 255", int'(phase_code), 127);
      tick();
      check("R6", "phase_code fwd wrap", int'(phase_code), 0);
      check("R4", "integ_mon held", int'(integ_mon), -1);

      // R9/R10: walk every quadrant at 15 codes per clock
      do_reset();
      kp_shift = 4'd0; ki_shift = 4'd15; max_step = 4'd15;
      pd_vote = 2'b01;
      for (int k = 1; k <= 9; k++) begin
         tick();
         check("R7", "quadrant walk code", int'(phase_code), (15 * k) % 128);
         check_map("R9", (15 * k) % 128);
      end

      // R5: saturation in both directions, R7: zero step limit
      do_reset();
      kp_shift = 4'd15; ki_shift = 4'd0; max_step = 4'd0;
      pd_vote = 2'b01;
      repeat (10) tick();
      check("R5", "integ_mon high", int'(integ_mon), 32767);
      check("R7", "code with zero limit", int'(phase_code), 0);
      pd_vote = 2'b11;
      repeat (20) tick();
      check("R5", "integ_mon low", int'(integ_mon), -32768);
      pd_vote = 2'b10;
      tick();
      check("R2", "integ_mon on 10", int'(integ_mon), -32768);
      check("R7", "code still 0", int'(phase_code), 0);

      // R8: freeze with a large pull held for several clocks
      max_step = 4'd15; kp_shift = 4'd0; freeze = 1'b1; pd_vote = 2'b01;
      repeat (4) tick();
      check("R8", "code frozen", int'(phase_code), 0);
      check("R8", "integ frozen", int'(integ_mon), -32768);

      // R1: reset mid-run clears state again
      do_reset();
      check("R1", "code after re-reset", int'(phase_code), 0);
      check("R1", "integ after re-reset", int'(integ_mon), 0);

      finish_run();
   end

endmodule